// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel attached to an 8-bit timer/counter. On every enabled timer clock it compares the external counter value with its active compare value. A real match raises a sticky compare flag and, when enabled, a one-cycle interrupt request. It also updates an internal output-compare bit. A two-bit action field decides whether that bit is toggled, cleared or set, and whether the bit overrides a general-purpose port pin.

How a CPU write to the compare value reaches the active register depends on the waveform mode. In the counting modes, a write lands in the active register at once. In the two pulse-width modes, the write lands in a staging register. Its value moves into the active register only at the turning point of the count, so no pulse is ever cut short. Software can fire a compare event by hand in the counting modes. That forced event changes the output bit but not the flag. A CPU write to the counter blanks the comparison at the next enabled timer clock.

The counter itself and the logic that produces the TOP and BOTTOM indications live outside this block. This block sees them only through its input ports.

Top module: `oc_channel`

## Requirements
- R1: After reset, ocr_active, cmp_flag, irq and oc_state are all 0.
- R2: With wgm 00 (normal) or 01 (clear on compare), an ocr_wr writes ocr_wdata straight to ocr_active, and the value is visible on the next cycle.
- R3: With wgm 10 (fast PWM) or 11 (phase-correct PWM), an ocr_wr only fills the staging register. ocr_active takes the staged value only on a cycle with tick and at_bottom (fast PWM) or with tick and at_top (phase-correct PWM). A write in that same cycle is staged for the following load.
- R4: A match is a cycle with tick high, cnt_val equal to ocr_active, and no blanking. On the next cycle cmp_flag is 1, and irq is 1 for exactly that cycle if irq_en was high at the match.
- R5: cmp_flag stays set until a cycle with flag_clr. If a match and flag_clr fall in the same cycle, the flag stays set. cmp_flag never rises without a match.
- R6: On a match, com selects the action on oc_state: 00 keeps it, 01 toggles it, 10 clears it, 11 sets it. In phase-correct PWM with cnt_down high, 10 sets and 11 clears.
- R7: In fast PWM, a cycle with tick and at_bottom but no match sets oc_state for com 10 and clears it for com 11.
- R8: In wgm 00 or 01, force_cmp applies the com action of R6 (without direction inversion) to oc_state and leaves cmp_flag unchanged. In PWM modes force_cmp has no effect.
- R9: A cnt_wr blanks the match at the next cycle that has tick, even if several cycles without tick come between. A cnt_wr in a cycle with tick blanks the following tick.
- R10: With com 00, pin_ovr is 0 and pin_out follows port_val. With any other com value, pin_ovr is 1 and pin_out equals oc_state, in the same cycle that com changes.
- R11: oc_state keeps its value across a change of wgm, and it changes only in a cycle with tick or force_cmp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable for this cycle |
| cnt_val | input | 8 | Current counter value |
| cnt_down | input | 1 | Counter is counting down |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| wgm | input | 2 | Waveform mode: 00 normal, 01 clear on compare, 10 fast PWM, 11 phase-correct PWM |
| com | input | 2 | Compare action and pin-override select |
| ocr_wr | input | 1 | CPU write strobe for the compare value |
| ocr_wdata | input | 8 | CPU write data for the compare value |
| cnt_wr | input | 1 | CPU wrote the counter this cycle |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | CPU writes one to the compare flag |
| irq_en | input | 1 | Interrupt enable |
| port_val | input | 1 | General-purpose port output value |
| ocr_active | output | 8 | Active compare value |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | One-cycle interrupt request |
| oc_state | output | 1 | Internal output-compare bit |
| pin_ovr | output | 1 | Pin is overridden by the compare output |
| pin_out | output | 1 | Value driven toward the pin |

## Verification
A stale or early-loaded active compare value shows up on ocr_active one cycle after the faulty load. In PWM modes it also moves the next match, so the error spreads to cmp_flag and oc_state at that match. A blanking latch stuck set or stuck clear shows up at the first tick after a counter write, as a missing or extra flag rise. A wrong output bit is visible on pin_out in the same cycle whenever com is non-zero. The bench runs a reference model step by step and compares every output on every cycle, so any such error is reported in the cycle it first reaches a port.

// File: rtl/oc_pkg.sv
// Shared types and the compare-action function for the output compare channel.
package oc_pkg;

    typedef enum logic [1:0] {
        WG_NORMAL = 2'b00,
        WG_CTC    = 2'b01,
        WG_FAST   = 2'b10,
        WG_PHASE  = 2'b11
    } wg_mode_t;

    typedef enum logic [1:0] {
        CM_OFF    = 2'b00,
        CM_TOGGLE = 2'b01,
        CM_CLEAR  = 2'b10,
        CM_SET    = 2'b11
    } cm_mode_t;

    // New output-compare bit for one compare event; invert swaps clear and set.
    function automatic logic oc_apply(cm_mode_t cm, logic cur, logic invert);
        logic r;
        unique case (cm)
            CM_OFF:    r = cur;
            CM_TOGGLE: r = ~cur;
            CM_CLEAR:  r = invert;
            CM_SET:    r = ~invert;
            default:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/oc_cmp_reg.sv
// Compare value storage.
// Holds the active compare value and, in PWM modes, a staging register that
// is copied into it at the mode's turning point.
// Assumes at_top / at_bottom are qualified by tick at this level.
// PWM_BUFFER = 0 builds a variant with no staging register.
module oc_cmp_reg
    import oc_pkg::*;
#(
    parameter int W          = 8,
    parameter bit PWM_BUFFER = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         at_top,
    input  logic         at_bottom,
    input  wg_mode_t     wg,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] act
);

    logic pwm;
    assign pwm = (wg == WG_FAST) || (wg == WG_PHASE);

    generate
        if (PWM_BUFFER) begin : g_buf
            logic [W-1:0] stage_q;
            logic         load;

            // Turning point at which the staged value becomes active.
            assign load = tick && (((wg == WG_FAST) && at_bottom) ||
                                   ((wg == WG_PHASE) && at_top));

            // Staging register: takes every CPU write.
            always_ff @(posedge clk) begin
                if (!rst_n)  stage_q <= '0;
                else if (wr) stage_q <= wdata;
            end

            // Active register: direct write in counting modes, staged load in PWM.
            always_ff @(posedge clk) begin
                if (!rst_n)             act <= '0;
                else if (!pwm && wr)    act <= wdata;
                else if (pwm && load)   act <= stage_q;
            end
        end else begin : g_direct
            logic unused_ok;
            assign unused_ok = &{1'b0, tick, at_top, at_bottom, pwm};

            // Active register written straight from the CPU in every mode.
            always_ff @(posedge clk) begin
                if (!rst_n)  act <= '0;
                else if (wr) act <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/oc_match.sv
// Comparator with counter-write blanking.
// Raises match_evt on an enabled timer clock when the counter equals the
// active compare value, unless the counter was written since the last tick.
module oc_match #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] act,
    input  logic         cnt_wr,
    output logic         match_evt,
    output logic         blank_q
);

    // Blanking latch: armed by a counter write, consumed by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      blank_q <= 1'b0;
        else if (cnt_wr) blank_q <= 1'b1;
        else if (tick)   blank_q <= 1'b0;
    end

    // Qualified equality.
    assign match_evt = tick && (cnt_val == act) && !blank_q;

endmodule

// File: rtl/oc_wave.sv
// Output-compare bit and pin selection.
// Applies the compare action on matches, forced compares and fast-PWM
// BOTTOM events; selects the pin source from com. State is independent of wg,
// so it is kept across mode changes.
module oc_wave
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     at_bottom,
    input  logic     cnt_down,
    input  wg_mode_t wg,
    input  cm_mode_t cm,
    input  logic     match_evt,
    input  logic     force_cmp,
    input  logic     port_val,
    output logic     oc_q,
    output logic     pin_ovr,
    output logic     pin_out
);

    logic pwm;
    logic oc_nxt;
    assign pwm = (wg == WG_FAST) || (wg == WG_PHASE);

    // Next output bit: a match wins over a force, which wins over a BOTTOM event.
    always_comb begin
        oc_nxt = oc_q;
        if (match_evt)
            oc_nxt = oc_apply(cm, oc_q, (wg == WG_PHASE) && cnt_down);
        else if (force_cmp && !pwm)
            oc_nxt = oc_apply(cm, oc_q, 1'b0);
        else if ((wg == WG_FAST) && tick && at_bottom && cm[1])
            oc_nxt = ~cm[0];
    end

    // Output-compare bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) oc_q <= 1'b0;
        else        oc_q <= oc_nxt;
    end

    // Pin source select, taking effect without delay.
    assign pin_ovr = (cm != CM_OFF);
    assign pin_out = pin_ovr ? oc_q : port_val;

endmodule

// File: rtl/oc_flag.sv
// Compare flag and interrupt request.
// Sticky flag set by a match and cleared by a CPU write of one; the set wins.
module oc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match_evt,
    input  logic flag_clr,
    input  logic irq_en,
    output logic flag_q,
    output logic irq_q
);

    // Sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (match_evt) flag_q <= 1'b1;
        else if (flag_clr)  flag_q <= 1'b0;
    end

    // One-cycle request aligned with the flag rising.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= match_evt && irq_en;
    end

endmodule

// File: rtl/oc_channel.sv
// Output compare channel top.
// Joins compare storage, comparator, output bit and flag.
// Assumes the external counter and the TOP/BOTTOM logic run on clk,
// with tick marking the cycles in which the counter advances.
module oc_channel
    import oc_pkg::*;
#(
    parameter int W          = 8,
    parameter bit PWM_BUFFER = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_down,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [1:0]   wgm,
    input  logic [1:0]   com,
    input  logic         ocr_wr,
    input  logic [W-1:0] ocr_wdata,
    input  logic         cnt_wr,
    input  logic         force_cmp,
    input  logic         flag_clr,
    input  logic         irq_en,
    input  logic         port_val,
    output logic [W-1:0] ocr_active,
    output logic         cmp_flag,
    output logic         irq,
    output logic         oc_state,
    output logic         pin_ovr,
    output logic         pin_out
);

    wg_mode_t wg;
    cm_mode_t cm;
    logic     match_evt;
    logic     blank_q;

    assign wg = wg_mode_t'(wgm);
    assign cm = cm_mode_t'(com);

    oc_cmp_reg #(.W(W), .PWM_BUFFER(PWM_BUFFER)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .at_top(at_top),
        .at_bottom(at_bottom), .wg(wg), .wr(ocr_wr), .wdata(ocr_wdata),
        .act(ocr_active)
    );

    oc_match #(.W(W)) u_match (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
        .act(ocr_active), .cnt_wr(cnt_wr), .match_evt(match_evt),
        .blank_q(blank_q)
    );

    oc_wave u_wave (
        .clk(clk), .rst_n(rst_n), .tick(tick), .at_bottom(at_bottom),
        .cnt_down(cnt_down), .wg(wg), .cm(cm), .match_evt(match_evt),
        .force_cmp(force_cmp), .port_val(port_val), .oc_q(oc_state),
        .pin_ovr(pin_ovr), .pin_out(pin_out)
    );

    oc_flag u_flag (
        .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .flag_clr(flag_clr),
        .irq_en(irq_en), .flag_q(cmp_flag), .irq_q(irq)
    );

endmodule

// File: rtl/oc_channel_chk.sv
// Property checker for oc_channel, attached with bind.
module oc_channel_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         at_top,
    input logic         at_bottom,
    input logic [1:0]   wgm,
    input logic         cnt_wr,
    input logic         force_cmp,
    input logic         port_val,
    input logic         match_evt,
    input logic [W-1:0] ocr_active,
    input logic         cmp_flag,
    input logic         irq,
    input logic         oc_state,
    input logic         pin_ovr,
    input logic         pin_out
);

    // R3: in PWM the active value holds except at a tick on TOP or BOTTOM
    a_r3_pwm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wgm[1] && !(tick && (at_top || at_bottom))) |=> $stable(ocr_active));

    // R4: a match is followed by a set flag
    a_r4_flag_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> cmp_flag);

    // R4: a request only comes with the flag
    a_r4_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cmp_flag);

    // R5: the flag never rises without a match
    a_r5_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> $past(match_evt));

    // R9: the comparison is blanked right after a counter write
    a_r9_blank_next: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !match_evt);

    // R10: pin source follows the override
    a_r10_pin_oc: assert property (@(posedge clk) disable iff (!rst_n)
        pin_ovr |-> (pin_out == oc_state));
    a_r10_pin_port: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_ovr |-> (pin_out == port_val));

    // R11: the output bit moves only with a tick or a force
    a_r11_oc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !force_cmp) |=> $stable(oc_state));

endmodule

bind oc_channel oc_channel_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .at_top(at_top),
    .at_bottom(at_bottom), .wgm(wgm), .cnt_wr(cnt_wr), .force_cmp(force_cmp),
    .port_val(port_val), .match_evt(match_evt), .ocr_active(ocr_active),
    .cmp_flag(cmp_flag), .irq(irq), .oc_state(oc_state), .pin_ovr(pin_ovr),
    .pin_out(pin_out)
);

// File: tb/tb_oc_channel.sv
`timescale 1ns/1ps
module tb_oc_channel;

    localparam int W        = 8;
    localparam int MAX_CYC  = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 0, cnt_down = 0, at_top = 0, at_bottom = 0;
    logic [W-1:0] cnt_val = '0, ocr_wdata = '0;
    logic [1:0]   wgm = 2'b00, com = 2'b00;
    logic         ocr_wr = 0, cnt_wr = 0, force_cmp = 0, flag_clr = 0;
    logic         irq_en = 0, port_val = 0;
    logic [W-1:0] ocr_active;
    logic         cmp_flag, irq, oc_state, pin_ovr, pin_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference model state
    logic [W-1:0] m_act, m_stg;
    logic         m_blk, m_oc, m_flag, m_irq;

    always #5 clk = ~clk;

    oc_channel #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
        .cnt_down(cnt_down), .at_top(at_top), .at_bottom(at_bottom),
        .wgm(wgm), .com(com), .ocr_wr(ocr_wr), .ocr_wdata(ocr_wdata),
        .cnt_wr(cnt_wr), .force_cmp(force_cmp), .flag_clr(flag_clr),
        .irq_en(irq_en), .port_val(port_val), .ocr_active(ocr_active),
        .cmp_flag(cmp_flag), .irq(irq), .oc_state(oc_state),
        .pin_ovr(pin_ovr), .pin_out(pin_out)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic act_fn(logic [1:0] c, logic cur, logic inv);
        case (c)
            2'b01:   return ~cur;
            2'b10:   return inv;
            2'b11:   return ~inv;
            default: return cur;
        endcase
    endfunction

    // Advance the model by one clock using the inputs held across the edge.
    task automatic model_step();
        logic match, pwm, ld;
        if (!rst_n) begin
            m_act = '0; m_stg = '0; m_blk = 0; m_oc = 0; m_flag = 0; m_irq = 0;
            return;
        end
        pwm   = wgm[1];
        match = tick && (cnt_val == m_act) && !m_blk;
        ld    = tick && ((wgm == 2'b10 && at_bottom) || (wgm == 2'b11 && at_top));
        if (match)                  m_oc = act_fn(com, m_oc, (wgm == 2'b11) && cnt_down);
        else if (force_cmp && !pwm) m_oc = act_fn(com, m_oc, 1'b0);
        else if (wgm == 2'b10 && tick && at_bottom && com[1]) m_oc = ~com[0];
        if (!pwm && ocr_wr)   m_act = ocr_wdata;
        else if (pwm && ld)   m_act = m_stg;
        if (ocr_wr) m_stg = ocr_wdata;
        if (cnt_wr)    m_blk = 1;
        else if (tick) m_blk = 0;
        m_irq = match && irq_en;
        if (match)         m_flag = 1;
        else if (flag_clr) m_flag = 0;
    endtask

    task automatic compare_all();
        logic ovr;
        ovr = (com != 2'b00);
        chk("R2/R3 ocr_active", ocr_active, m_act);
        chk("R4/R5 cmp_flag", cmp_flag, m_flag);
        chk("R4 irq", irq, m_irq);
        chk("R6/R7/R8 oc_state", oc_state, m_oc);
        chk("R10 pin_ovr", pin_ovr, ovr);
        chk("R10 pin_out", pin_out, ovr ? m_oc : port_val);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        tick = 0; ocr_wr = 0; cnt_wr = 0; force_cmp = 0; flag_clr = 0;
        at_top = 0; at_bottom = 0;
    endtask

    initial begin : watchdog
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        @(negedge clk);
        cyc(); cyc();
        // R1: reset state
        chk("R1 ocr_active", ocr_active, 0);
        chk("R1 cmp_flag", cmp_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 oc_state", oc_state, 0);
        rst_n = 1;
        cyc();

        // R2: direct write in normal mode
        wgm = 2'b00; ocr_wr = 1; ocr_wdata = 8'd40; cyc(); idle();
        chk("R2 direct write", ocr_active, 40);

        // R4/R6: match toggles, sets flag, pulses irq
        com = 2'b01; irq_en = 1; tick = 1; cnt_val = 8'd40; cyc(); idle();
        chk("R4 flag on match", cmp_flag, 1);
        chk("R4 irq pulse", irq, 1);
        chk("R6 toggle", oc_state, 1);
        cyc();
        chk("R4 irq one cycle", irq, 0);

        // R5: clear together with a match keeps flag
        tick = 1; flag_clr = 1; cyc(); idle();
        chk("R5 set wins", cmp_flag, 1);
        flag_clr = 1; cyc(); idle();
        chk("R5 clear", cmp_flag, 0);

        // R9: counter write, clock stopped, then the tick is blanked
        cnt_wr = 1; cyc(); idle();
        cyc(); cyc();
        tick = 1; cnt_val = 8'd40; cyc(); idle();
        chk("R9 blanked tick", cmp_flag, 0);
        tick = 1; cyc(); idle();
        chk("R9 blank consumed", cmp_flag, 1);
        flag_clr = 1; cyc(); idle();

        // R8: force sets without flag
        com = 2'b11; force_cmp = 1; cyc(); idle();
        chk("R8 force applies", oc_state, 1);
        chk("R8 force no flag", cmp_flag, 0);
        com = 2'b10; force_cmp = 1; cyc(); idle();
        chk("R8 force clear", oc_state, 0);

        // R3: staged write in fast PWM waits for BOTTOM
        wgm = 2'b10; ocr_wr = 1; ocr_wdata = 8'd99; cyc(); idle();
        chk("R3 staged hold", ocr_active, 40);
        tick = 1; at_top = 1; cnt_val = 8'd5; cyc(); idle();
        chk("R3 fast ignores TOP", ocr_active, 40);
        // R7: BOTTOM with com 10 sets
        tick = 1; at_bottom = 1; cnt_val = 8'd0; cyc(); idle();
        chk("R3 fast load", ocr_active, 99);
        chk("R7 bottom set", oc_state, 1);
        // R8: force ignored in PWM
        com = 2'b01; force_cmp = 1; cyc(); idle();
        chk("R8 force ignored in PWM", oc_state, 1);

        // R11: mode change keeps the bit
        wgm = 2'b11; cyc();
        chk("R11 kept on mode change", oc_state, 1);
        // R3 phase-correct loads at TOP; R6 inverted on down count
        ocr_wr = 1; ocr_wdata = 8'd7; cyc(); idle();
        tick = 1; at_bottom = 1; cnt_val = 8'd0; cyc(); idle();
        chk("R3 phase ignores BOTTOM", ocr_active, 99);
        tick = 1; at_top = 1; cnt_val = 8'd200; cyc(); idle();
        chk("R3 phase load at TOP", ocr_active, 7);
        com = 2'b10; tick = 1; cnt_down = 1; cnt_val = 8'd7; cyc(); idle();
        chk("R6 down-count inverts clear", oc_state, 1);
        cnt_down = 0;

        // R10: pin follows port when disconnected
        com = 2'b00; port_val = 1; #1;
        chk("R10 port drive", pin_out, 1);
        chk("R10 no override", pin_ovr, 0);
        cyc();

        // Random phase mixing all inputs
        for (int i = 0; i < 4000; i++) begin
            tick      = ($urandom % 3) != 0;
            wgm       = 2'($urandom);
            com       = 2'($urandom);
            cnt_down  = 1'($urandom);
            at_top    = ($urandom % 6) == 0;
            at_bottom = ($urandom % 6) == 0;
            cnt_val   = 8'($urandom % 8);
            ocr_wr    = ($urandom % 5) == 0;
            ocr_wdata = 8'($urandom % 8);
            cnt_wr    = ($urandom % 8) == 0;
            force_cmp = ($urandom % 7) == 0;
            flag_clr  = ($urandom % 4) == 0;
            irq_en    = 1'($urandom);
            port_val  = 1'($urandom);
            cyc();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule